// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel on a 16-bit free-running timer. A divide-by-four prescaler advances the counter. At the end of every prescaler period the counter is compared with a 16-bit compare value that software keeps in two byte registers. When the two are equal, the block sets a sticky compare flag and copies a programmed level bit into the latch that drives the compare pin. If the enable bit is set, it also raises an interrupt request.

Software reaches the channel through a byte-wide register port with three addresses:

| Address | Register |
|---|---|
| 0 | High compare byte |
| 1 | Low compare byte |
| 2 | Control/status byte |

A write to the high byte blocks matching until the low byte is written, so a match cannot fire on a half-updated compare value. A separate strobe clears the flag. The compare bytes have no reset and keep their contents through reset.

Top module: `ocu_top`

## Requirements
- R1: The high byte (address 0) and low byte (address 1) read back exactly what was last written, and timer activity never alters them.
- R2: Asserting reset leaves both compare bytes unchanged.
- R3: After reset is released, the counter holds value V from rising edge 4V to rising edge 4V+3. The compare for value V is evaluated on rising edge 4V+4, so the flag first reads 1 after that edge and reads 0 after edge 4V+3.
- R4: A valid match sets the compare flag and loads the level bit into the pin latch on the same edge.
- R5: The interrupt output is high exactly while both the compare flag and the enable bit are 1, and it follows a later change of the enable bit.
- R6: A write to the high byte suppresses matching until the low byte is written. A write to the low byte alone does not suppress matching.
- R7: The pin latch takes the level bit on every valid match, even when the flag is already set. Changing the level bit without a match leaves the pin unchanged.
- R8: A pulse on the flag clear input clears the flag. If a match falls in the same cycle as the clear, the flag stays set.
- R9: Reset sets the counter, the prescaler phase, the flag, the enable bit, the level bit, the pin latch and the write interlock to zero.
- R10: The control/status byte at address 2 has these fields: bit 0 is the interrupt enable, bit 1 is the level bit, and bit 7 is a read-only copy of the flag. Bits 6..2 read as 0, and writes to bits 7..2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register byte address (0 high, 1 low, 2 control/status) |
| busWe | input | 1 | Write strobe for the addressed byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed byte, combinational |
| flagClr | input | 1 | Single-cycle strobe that clears the compare flag |
| cmpPin | output | 1 | Compare pin latch |
| cmpIrq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and a prescaler divide of four. It counts rising edges from the release of reset, so it predicts the exact edge of every match as 4V+4. Compare values run from a few counts up to values that carry into the high byte. A chained sweep of sixteen targets alternates the level bit, so the pin toggles on each match while the flag stays set across matches. This configuration places the interlock, the clear-versus-match collision and the reset retention of the compare bytes within a few thousand cycles.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;

  localparam int CTL_IE   = 0;
  localparam int CTL_LVL  = 1;
  localparam int CTL_FLAG = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;     // end of prescaler period
    logic cmpEn;    // interlock open
    logic wrHi;
    logic wrLo;
    logic wrCtl;
    logic clrFlag;
  } ocuStrobe_t;

endpackage

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              flagClr,
  output ocuStrobe_t        strb
);

  localparam int PH_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PRE_DIV - 1);

  logic tickInt;
  logic inhibit;

  generate
    if (PRE_DIV > 1) begin : g_prescale
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          phase <= '0;
        end else if (phase == PH_LAST) begin
          phase <= '0;
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
      assign tickInt = (phase == PH_LAST);
    end else begin : g_noprescale
      assign tickInt = 1'b1;
    end
  endgenerate

  logic hiWrite;
  logic loWrite;
  logic ctlWrite;

  always_comb begin
    hiWrite  = busWe && (busAddr == ADDR_HI);
    loWrite  = busWe && (busAddr == ADDR_LO);
    ctlWrite = busWe && (busAddr == ADDR_CTL);
  end

  // byte-write interlock: high byte arms it, low byte releases it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhibit <= 1'b0;
    end else if (hiWrite) begin
      inhibit <= 1'b1;
    end else if (loWrite) begin
      inhibit <= 1'b0;
    end
  end

  always_comb begin
    strb.tick    = tickInt;
    strb.cmpEn   = !inhibit;
    strb.wrHi    = hiWrite;
    strb.wrLo    = loWrite;
    strb.wrCtl   = ctlWrite;
    strb.clrFlag = flagClr;
  end

endmodule

// File: rtl/ocu_dpath.sv
module ocu_dpath
  import ocu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ocuStrobe_t          strb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  output logic                cmpPin,
  output logic                cmpIrq,
  output logic [2*BYTE_W-1:0] cntObs,
  output logic                matchObs,
  output logic                flagObs,
  output logic                ieObs,
  output logic                lvlObs
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] cmpHi;
  logic [BYTE_W-1:0] cmpLo;
  logic              flag;
  logic              intEn;
  logic              level;
  logic              pinLatch;
  logic              matchHit;

  // free-running counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.tick) begin
      count <= count + CNT_W'(1);
    end
  end

  // compare bytes: no reset, kept across reset
  always_ff @(posedge clk) begin
    if (strb.wrHi) begin
      cmpHi <= busWdata;
    end
    if (strb.wrLo) begin
      cmpLo <= busWdata;
    end
  end

  always_comb begin
    matchHit = strb.tick && strb.cmpEn && (count == {cmpHi, cmpLo});
  end

  // control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= 1'b0;
      level <= 1'b0;
    end else if (strb.wrCtl) begin
      intEn <= busWdata[CTL_IE];
      level <= busWdata[CTL_LVL];
    end
  end

  // sticky flag, match beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (matchHit) begin
      flag <= 1'b1;
    end else if (strb.clrFlag) begin
      flag <= 1'b0;
    end
  end

  // pin latch loads on every valid match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinLatch <= 1'b0;
    end else if (matchHit) begin
      pinLatch <= level;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_HI:  busRdata = cmpHi;
      ADDR_LO:  busRdata = cmpLo;
      ADDR_CTL: begin
        busRdata[CTL_IE]   = intEn;
        busRdata[CTL_LVL]  = level;
        busRdata[CTL_FLAG] = flag;
      end
      default:  busRdata = '0;
    endcase
  end

  assign cmpPin   = pinLatch;
  assign cmpIrq   = flag && intEn;
  assign cntObs   = count;
  assign matchObs = matchHit;
  assign flagObs  = flag;
  assign ieObs    = intEn;
  assign lvlObs   = level;

endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              flagClr,
  output logic              cmpPin,
  output logic              cmpIrq
);

  localparam int CNT_W = 2 * BYTE_W;

  ocuStrobe_t       strb;
  logic [CNT_W-1:0] cntObs;
  logic             matchObs;
  logic             flagObs;
  logic             ieObs;
  logic             lvlObs;
  logic             tickObs;
  logic             inhibitObs;

  ocu_ctrl #(.PRE_DIV(PRE_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .flagClr (flagClr),
    .strb    (strb)
  );

  ocu_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cmpPin   (cmpPin),
    .cmpIrq   (cmpIrq),
    .cntObs   (cntObs),
    .matchObs (matchObs),
    .flagObs  (flagObs),
    .ieObs    (ieObs),
    .lvlObs   (lvlObs)
  );

  assign tickObs    = strb.tick;
  assign inhibitObs = !strb.cmpEn;

endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
  parameter int PRE_DIV = 4,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             inhibit,
  input logic             matchHit,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             ie,
  input logic             lvl,
  input logic             flagClr,
  input logic             pin,
  input logic             irq
);

  // R3: counter steps only on a tick
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cnt == $past(cnt) + CNT_W'(1)));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(cnt));

  generate
    if (PRE_DIV > 1) begin : g_gap
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

  // R4: match sets flag and loads level into pin
  p_match_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> flag);
  p_match_pin_r4: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> (pin == $past(lvl)));

  // R5: interrupt only with flag and enable
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flag && ie));

  // R6: no match while interlock armed
  p_inhibit_r6: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |-> !matchHit);

  // R7: pin moves only after a match
  p_pin_only_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pin) |-> $past(matchHit));

  // R8: flag sticks until cleared
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag);
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(matchHit));

endmodule

bind ocu_top ocu_chk #(.PRE_DIV(PRE_DIV), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tick     (tickObs),
  .inhibit  (inhibitObs),
  .matchHit (matchObs),
  .cnt      (cntObs),
  .flag     (flagObs),
  .ie       (ieObs),
  .lvl      (lvlObs),
  .flagClr  (flagClr),
  .pin      (cmpPin),
  .irq      (cmpIrq)
);

// File: tb/tb_ocu_top.sv
`timescale 1ns/1ps
module tb_ocu_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] busAddr;
  logic       busWe;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       flagClr;
  logic       cmpPin;
  logic       cmpIrq;

  int total = 0;
  int bad = 0;
  int edgeCnt = 0;

  always #5 clk = ~clk;

  ocu_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .flagClr  (flagClr),
    .cmpPin   (cmpPin),
    .cmpIrq   (cmpIrq)
  );

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (edge %0d)", req, act, exp, edgeCnt);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitEdge(input int n);
    if (edgeCnt > n) check(1'b0, "bench-order", edgeCnt, n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  function automatic logic flagOf(input logic [7:0] c);
    return c[7];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic       pinExp;
    int         v;
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; flagClr = 1'b0;
    repeat (3) @(negedge clk);

    // R9: reset state
    rd(2'd2, r);
    check(r == 8'h00, "R9 ctl", r, 8'h00);
    check(cmpPin == 1'b0, "R9 pin", cmpPin, 0);
    check(cmpIrq == 1'b0, "R9 irq", cmpIrq, 0);

    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, r); check(r == 8'hA5, "R1 hi", r, 8'hA5);
    rd(2'd1, r); check(r == 8'h3C, "R1 lo", r, 8'h3C);

    // R2: reset keeps compare bytes
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd0, r); check(r == 8'hA5, "R2 hi", r, 8'hA5);
    rd(2'd1, r); check(r == 8'h3C, "R2 lo", r, 8'h3C);

    // program V=20 while in reset, release with edge count 0
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd20);
    @(negedge clk); rstN = 1'b1;
    wr(2'd2, 8'h03);

    // R3/R4/R5: match at edge 84
    waitEdge(83);
    rd(2'd2, r);
    check(flagOf(r) == 1'b0, "R3 early flag", flagOf(r), 0);
    check(cmpPin == 1'b0, "R4 early pin", cmpPin, 0);
    check(cmpIrq == 1'b0, "R5 early irq", cmpIrq, 0);
    waitEdge(84);
    rd(2'd2, r);
    check(flagOf(r) == 1'b1, "R3 flag", flagOf(r), 1);
    check(cmpPin == 1'b1, "R4 pin", cmpPin, 1);
    check(cmpIrq == 1'b1, "R5 irq", cmpIrq, 1);
    check(r == 8'h83, "R10 ctl read", r, 8'h83);

    // R7: level change alone leaves pin; match with flag set loads it
    wr(2'd2, 8'h01);
    wr(2'd1, 8'd30);
    waitEdge(123);
    check(cmpPin == 1'b1, "R7 no-match pin", cmpPin, 1);
    waitEdge(124);
    check(cmpPin == 1'b0, "R7 rematch pin", cmpPin, 0);
    rd(2'd2, r);
    check(flagOf(r) == 1'b1, "R7 flag kept", flagOf(r), 1);

    // R8: plain clear
    clearFlag();
    rd(2'd2, r);
    check(flagOf(r) == 1'b0, "R8 clear", flagOf(r), 0);
    check(cmpIrq == 1'b0, "R5 irq after clear", cmpIrq, 0);
    wr(2'd2, 8'h03);
    wr(2'd1, 8'd40);
    // R8: clear coinciding with match at edge 164
    waitEdge(163);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    rd(2'd2, r);
    check(flagOf(r) == 1'b1, "R8 match wins", flagOf(r), 1);
    check(cmpPin == 1'b1, "R8 pin", cmpPin, 1);
    clearFlag();

    // R6: high write suppresses until low write
    wr(2'd1, 8'd50);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    waitEdge(204);
    rd(2'd2, r);
    check(flagOf(r) == 1'b0, "R6 inhibited flag", flagOf(r), 0);
    check(cmpPin == 1'b1, "R6 inhibited pin", cmpPin, 1);
    wr(2'd1, 8'd60);
    waitEdge(244);
    rd(2'd2, r);
    check(flagOf(r) == 1'b1, "R6 released flag", flagOf(r), 1);
    check(cmpPin == 1'b0, "R6 released pin", cmpPin, 0);
    check(cmpIrq == 1'b0, "R5 irq masked", cmpIrq, 0);
    wr(2'd2, 8'h01);
    check(cmpIrq == 1'b1, "R5 irq late enable", cmpIrq, 1);
    rd(2'd0, r); check(r == 8'h00, "R1 hi after match", r, 8'h00);
    rd(2'd1, r); check(r == 8'd60, "R1 lo after match", r, 8'd60);

    // R10: read-only and unused bits
    clearFlag();
    wr(2'd2, 8'hFF);
    rd(2'd2, r);
    check(r == 8'h03, "R10 ro bits", r, 8'h03);

    // R3: match needing the high byte, V=256
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    waitEdge(1027);
    rd(2'd2, r);
    check(flagOf(r) == 1'b0, "R3 hi early", flagOf(r), 0);
    waitEdge(1028);
    rd(2'd2, r);
    check(flagOf(r) == 1'b1, "R3 hi match", flagOf(r), 1);
    check(cmpPin == 1'b0, "R4 pin level0", cmpPin, 0);
    pinExp = 1'b0;

    // sweep of chained targets, alternating level, flag left set
    clearFlag();
    for (int i = 0; i < 16; i++) begin
      v = 1100 + 37 * i;
      wr(2'd0, 8'(v >> 8));
      wr(2'd1, 8'(v));
      wr(2'd2, {6'b0, 1'(~i[0]), 1'b1});
      waitEdge(4 * v + 3);
      check(cmpPin == pinExp, "R7 sweep pre", cmpPin, pinExp);
      if (i == 0) check(cmpIrq == 1'b0, "R5 sweep pre irq", cmpIrq, 0);
      waitEdge(4 * v + 4);
      pinExp = ~i[0];
      rd(2'd2, r);
      check(flagOf(r) == 1'b1, "R3 sweep flag", flagOf(r), 1);
      check(cmpPin == pinExp, "R4 sweep pin", cmpPin, pinExp);
      check(cmpIrq == 1'b1, "R5 sweep irq", cmpIrq, 1);
    end
    rd(2'd0, r); check(r == 8'(v >> 8), "R1 final hi", r, 8'(v >> 8));
    rd(2'd1, r); check(r == 8'(v), "R1 final lo", r, 8'(v));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule